// File: doc/BRIEF.md
# Byte Serializer-Deserializer with Loopback Routing

This block converts between a byte-wide parallel interface and a one-bit serial line, all in one clock domain. Bit timing on each side comes from a clock-enable input rather than a separate clock. On the transmit side, a byte is taken in once every eight bit enables and is shifted out most significant bit first. On the receive side, serial bits are registered and shifted into a deserializer. Every eighth bit it presents a byte together with a one-cycle strobe. A frame aligner can re-phase that byte boundary with a single pulse.

Three control inputs steer the two paths independently. Facility loopback sends the received serial stream to the serial output, and receive deserialization carries on as normal. Equipment loopback feeds the internal transmit stream into the deserializer. With both set, the block is in split loopback. Loop timing makes transmit bit timing follow the receive bit enable. A loss-of-signal input blanks the parallel receive data. Mode changes are held back to byte boundaries, so no byte ever mixes bits from two sources.

Top module: `byte_serdes_loop`

## Requirements
- R1: Each enabled transmit bit cycle (the local bit enable, or the receive bit enable in loop timing) shifts one bit out on `tx_ser_o`, most significant bit first. `tx_byte_stb_o` is high in every eighth enabled cycle, counted from reset, and `tx_byte_i` is captured at that edge. The first byte starts on the following enable, and zeros are sent until then.
- R2: Every receive bit enable registers `rx_ser_i` into a line flop. The deserializer shifts in the previous line value, newest bit in bit 0. After eight deserializer bits the last eight are latched onto `rx_byte_o`, and `rx_byte_stb_o` pulses for exactly the following cycle.
- R3: In facility loopback, `tx_ser_o` carries the receive line flop, and the deserializer still takes the received stream.
- R4: In equipment loopback, the deserializer takes the transmit shift register's outgoing bit at transmit bit timing, and `tx_ser_o` still carries transmit data.
- R5: With both loopbacks selected, `tx_ser_o` carries the receive line flop and the deserializer takes the transmit bit stream.
- R6: In loop timing, the transmit side advances on `rx_bit_en_i` instead of `loc_bit_en_i`.
- R7: While `los_i` is high, `rx_byte_o` reads zero in the same cycle. The held byte returns when `los_i` falls.
- R8: When `rst_ni` is low, both shift registers, both bit counters, the line flop, the held byte and all mode selections are cleared, and every output reads zero.
- R9: `align_load_i` that is high in a deserializer bit cycle ends the byte on that bit. The last eight bits are delivered and the bit count restarts.
- R10: Facility loopback and loop timing requests are sampled only at the edge where `tx_byte_stb_o` is high.
- R11: The equipment loopback request is sampled only at a deserializer byte boundary, the edge before `rx_byte_stb_o` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| loc_bit_en_i | input | 1 | Local transmit bit-clock enable |
| rx_bit_en_i | input | 1 | Receive bit-clock enable |
| rx_ser_i | input | 1 | Serial receive data |
| tx_byte_i | input | BYTE_W | Parallel transmit byte |
| fac_loop_i | input | 1 | Facility loopback request |
| eq_loop_i | input | 1 | Equipment loopback request |
| loop_time_i | input | 1 | Loop timing request |
| los_i | input | 1 | Loss of signal, blanks receive data |
| align_load_i | input | 1 | Deserializer boundary re-phase pulse |
| tx_ser_o | output | 1 | Serial transmit data |
| tx_byte_stb_o | output | 1 | Transmit byte strobe, capture cycle |
| rx_byte_o | output | BYTE_W | Parallel receive byte |
| rx_byte_stb_o | output | 1 | Receive byte valid pulse |

## Verification
Two pairs of events can land in the same cycle. A mode request can change on the very edge that is a byte boundary, and an alignment pulse can coincide with the eighth bit that would end the byte anyway. A stress phase flips the loopback and timing requests at random while alignment pulses and both bit enables run at high density, so both kinds of coincidence occur many times. A behavioural model keeps a queue of the last eight bits and one integer position per side, and every output is compared against it on every cycle. The model shows whether a request sampled on a boundary edge governs the next byte, and whether a coinciding alignment pulse delivers exactly one byte.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  typedef struct packed {
    logic fac;
    logic eq;
    logic lt;
  } loop_sel_t;
endpackage

// File: rtl/bsd_tx_ser.sv
module bsd_tx_ser #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bit_en_i,
  input  logic [W-1:0] byte_i,
  output logic         bit_o,
  output logic         load_o
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;

  assign load_o = bit_en_i && (cnt_q == LAST);
  assign bit_o  = sh_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (bit_en_i) begin
      if (cnt_q == LAST) begin
        sh_q  <= byte_i;
        cnt_q <= '0;
      end else begin
        sh_q  <= {sh_q[W-2:0], 1'b0};
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/bsd_rx_des.sv
module bsd_rx_des #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bit_en_i,
  input  logic         bit_i,
  input  logic         align_i,
  output logic [W-1:0] byte_o,
  output logic         stb_o,
  output logic         bound_o
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sh_q, byte_q, nxt;
  logic [CW-1:0] cnt_q;
  logic          stb_q;

  assign nxt     = {sh_q[W-2:0], bit_i};
  // alignment pulse closes the byte on the bit entering now
  assign bound_o = bit_en_i && ((cnt_q == LAST) || align_i);
  assign byte_o  = byte_q;
  assign stb_o   = stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      byte_q <= '0;
      cnt_q  <= '0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= bound_o;
      if (bit_en_i) begin
        sh_q <= nxt;
        if (bound_o) begin
          byte_q <= nxt;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/bsd_route.sv
module bsd_route
  import bsd_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      loc_en_i,
  input  logic      rx_en_i,
  input  logic      rx_ser_i,
  input  loop_sel_t req_i,
  input  logic      tx_bound_i,
  input  logic      rx_bound_i,
  input  logic      tx_bit_i,
  output logic      tx_en_o,
  output logic      des_en_o,
  output logic      des_bit_o,
  output logic      ser_o,
  output loop_sel_t sel_o
);
  loop_sel_t sel_q;
  logic      line_q;

  assign tx_en_o   = sel_q.lt ? rx_en_i : loc_en_i;
  assign des_en_o  = sel_q.eq ? tx_en_o : rx_en_i;
  assign des_bit_o = sel_q.eq ? tx_bit_i : line_q;
  assign ser_o     = sel_q.fac ? line_q : tx_bit_i;
  assign sel_o     = sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      line_q <= 1'b0;
    end else begin
      if (rx_en_i) line_q <= rx_ser_i;
      // transmit-side selections move only on a transmit byte edge
      if (tx_bound_i) begin
        sel_q.fac <= req_i.fac;
        sel_q.lt  <= req_i.lt;
      end
      if (rx_bound_i) sel_q.eq <= req_i.eq;
    end
  end
endmodule

// File: rtl/byte_serdes_loop.sv
module byte_serdes_loop
  import bsd_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              loc_bit_en_i,
  input  logic              rx_bit_en_i,
  input  logic              rx_ser_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic              fac_loop_i,
  input  logic              eq_loop_i,
  input  logic              loop_time_i,
  input  logic              los_i,
  input  logic              align_load_i,
  output logic              tx_ser_o,
  output logic              tx_byte_stb_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_byte_stb_o
);
  loop_sel_t         req, sel_q;
  logic              tx_en, des_en, des_bit, tx_bit, tx_load, rx_bound;
  logic [BYTE_W-1:0] des_byte;

  assign req = '{fac: fac_loop_i, eq: eq_loop_i, lt: loop_time_i};

  bsd_route u_route (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .loc_en_i   (loc_bit_en_i),
    .rx_en_i    (rx_bit_en_i),
    .rx_ser_i   (rx_ser_i),
    .req_i      (req),
    .tx_bound_i (tx_load),
    .rx_bound_i (rx_bound),
    .tx_bit_i   (tx_bit),
    .tx_en_o    (tx_en),
    .des_en_o   (des_en),
    .des_bit_o  (des_bit),
    .ser_o      (tx_ser_o),
    .sel_o      (sel_q)
  );

  bsd_tx_ser #(.W(BYTE_W)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_en_i (tx_en),
    .byte_i   (tx_byte_i),
    .bit_o    (tx_bit),
    .load_o   (tx_load)
  );

  bsd_rx_des #(.W(BYTE_W)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_en_i (des_en),
    .bit_i    (des_bit),
    .align_i  (align_load_i),
    .byte_o   (des_byte),
    .stb_o    (rx_byte_stb_o),
    .bound_o  (rx_bound)
  );

  assign tx_byte_stb_o = tx_load;
  assign rx_byte_o     = los_i ? '0 : des_byte;
endmodule

// File: rtl/bsd_chk.sv
module bsd_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         los_i,
  input logic [W-1:0] rx_byte_i,
  input logic         rx_stb_i,
  input logic         tx_en_i,
  input logic         tx_load_i,
  input logic         des_en_i,
  input logic         rx_bound_i,
  input logic         fac_i,
  input logic         lt_i,
  input logic         eq_i
);
  int unsigned tx_seen, rx_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_seen <= 0;
      rx_seen <= 0;
    end else begin
      if (tx_en_i) tx_seen <= tx_load_i ? 0 : tx_seen + 1;
      if (des_en_i) rx_seen <= rx_bound_i ? 0 : rx_seen + 1;
    end
  end

  // R1
  tx_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_i |-> (tx_load_i == (tx_seen == W - 1)));
  // R9
  rx_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (des_en_i && rx_seen == W - 1) |-> rx_bound_i);
  // R2
  rx_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_bound_i |=> rx_stb_i);
  // R7
  los_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    los_i |-> (rx_byte_i == '0));
  // R10
  tx_mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_load_i |=> $stable({fac_i, lt_i}));
  // R11
  rx_mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_bound_i |=> $stable(eq_i));
endmodule

bind byte_serdes_loop bsd_chk #(.W(BYTE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .los_i      (los_i),
  .rx_byte_i  (rx_byte_o),
  .rx_stb_i   (rx_byte_stb_o),
  .tx_en_i    (tx_en),
  .tx_load_i  (tx_load),
  .des_en_i   (des_en),
  .rx_bound_i (rx_bound),
  .fac_i      (sel_q.fac),
  .lt_i       (sel_q.lt),
  .eq_i       (sel_q.eq)
);

// File: tb/byte_serdes_loop_tb.sv
module byte_serdes_loop_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         loc_bit_en = 1'b0, rx_bit_en = 1'b0, rx_ser = 1'b0;
  logic [W-1:0] tx_byte = '0;
  logic         fac_loop = 1'b0, eq_loop = 1'b0, loop_time = 1'b0;
  logic         los = 1'b0, align_load = 1'b0;
  logic         tx_ser, tx_byte_stb, rx_byte_stb;
  logic [W-1:0] rx_byte;

  always #5 clk = ~clk;

  byte_serdes_loop #(.BYTE_W(W)) u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .loc_bit_en_i  (loc_bit_en),
    .rx_bit_en_i   (rx_bit_en),
    .rx_ser_i      (rx_ser),
    .tx_byte_i     (tx_byte),
    .fac_loop_i    (fac_loop),
    .eq_loop_i     (eq_loop),
    .loop_time_i   (loop_time),
    .los_i         (los),
    .align_load_i  (align_load),
    .tx_ser_o      (tx_ser),
    .tx_byte_stb_o (tx_byte_stb),
    .rx_byte_o     (rx_byte),
    .rx_byte_stb_o (rx_byte_stb)
  );

  int    total = 0, bad = 0;
  bit    done = 0;
  string phase_tag = "R8";

  // behavioural reference
  bit [W-1:0] m_tx_byte, m_rx_byte;
  int         m_tx_idx, m_cnt;
  bit         m_fac, m_eq, m_lt, m_line, m_stb;
  bit         m_hist[$];

  function automatic bit m_tx_en();
    return m_lt ? rx_bit_en : loc_bit_en;
  endfunction

  function automatic bit m_txbit();
    return m_tx_byte[W-1-m_tx_idx];
  endfunction

  task automatic m_reset();
    m_tx_byte = '0; m_rx_byte = '0; m_tx_idx = 0; m_cnt = 0;
    m_fac = 0; m_eq = 0; m_lt = 0; m_line = 0; m_stb = 0;
    m_hist.delete();
    for (int i = 0; i < W; i++) m_hist.push_back(1'b0);
  endtask

  initial m_reset();

  always @(posedge clk) begin
    bit te, tb, de, db;
    if (!rst_ni) m_reset();
    else begin
      te = m_tx_en();
      tb = m_txbit();
      de = m_eq ? te : rx_bit_en;
      db = m_eq ? tb : m_line;
      m_stb = 0;
      if (de) begin
        m_hist.push_back(db);
        void'(m_hist.pop_front());
        m_cnt++;
        if (m_cnt == W || align_load) begin
          for (int i = 0; i < W; i++) m_rx_byte[W-1-i] = m_hist[i];
          m_cnt = 0;
          m_eq  = eq_loop;
          m_stb = 1;
        end
      end
      if (te) begin
        if (m_tx_idx == W - 1) begin
          m_tx_byte = tx_byte;
          m_tx_idx  = 0;
          m_fac     = fac_loop;
          m_lt      = loop_time;
        end else m_tx_idx++;
      end
      if (rx_bit_en) m_line = rx_ser;
    end
  end

  task automatic chk(input logic [W-1:0] got, input logic [W-1:0] exp,
                     input string tag, input string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s (%s) %s got=%h exp=%h at %0t", tag, phase_tag, what, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    string t;
    t = m_lt ? "R6" : "R1";
    chk(W'(tx_byte_stb), W'(m_tx_en() && m_tx_idx == W - 1), t, "tx_byte_stb");
    t = (m_fac && m_eq) ? "R5" : (m_fac ? "R3" : "R1");
    chk(W'(tx_ser), W'(m_fac ? m_line : m_txbit()), t, "tx_ser");
    t = los ? "R7" : (m_eq ? (m_fac ? "R5" : "R4") : "R2");
    chk(rx_byte, los ? '0 : m_rx_byte, t, "rx_byte");
    chk(W'(rx_byte_stb), W'(m_stb), "R2", "rx_byte_stb");
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  function automatic bit chance(input int n);
    return ($urandom_range(n - 1) == 0);
  endfunction

  // one phase of random traffic; den=0 keeps that control constant
  task automatic run(input string tag, input int n, input int lp, input int rp,
                     input int mode_den, input int los_den, input int al_den);
    phase_tag = tag;
    for (int c = 0; c < n; c++) begin
      step();
      loc_bit_en = chance(lp);
      rx_bit_en  = chance(rp);
      rx_ser     = 1'($urandom);
      tx_byte    = W'($urandom);
      if (mode_den > 0 && chance(mode_den)) begin
        case ($urandom_range(2))
          0: fac_loop = ~fac_loop;
          1: eq_loop = ~eq_loop;
          default: loop_time = ~loop_time;
        endcase
      end
      if (los_den > 0 && chance(los_den)) los = ~los;
      align_load = (al_den > 0) ? chance(al_den) : 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    phase_tag = "R8";
    chk(W'(tx_ser), '0, "R8", "reset tx_ser");
    chk(W'(tx_byte_stb), '0, "R8", "reset tx_byte_stb");
    chk(rx_byte, '0, "R8", "reset rx_byte");
    chk(W'(rx_byte_stb), '0, "R8", "reset rx_byte_stb");
    rst_ni = 1'b1;
    run("R1", 1500, 1, 1, 0, 0, 0);
    run("R2", 2000, 3, 2, 0, 0, 0);
    fac_loop = 1'b1;
    run("R3", 2000, 2, 3, 0, 0, 0);
    fac_loop = 1'b0; eq_loop = 1'b1;
    run("R4", 2000, 2, 3, 0, 0, 0);
    fac_loop = 1'b1;
    run("R5", 2000, 3, 2, 0, 0, 0);
    fac_loop = 1'b0; eq_loop = 1'b0; loop_time = 1'b1;
    run("R6", 2000, 1, 3, 0, 0, 0);
    loop_time = 1'b0;
    run("R7", 2000, 2, 1, 0, 30, 0);
    los = 1'b0;
    run("R9", 2000, 2, 1, 0, 0, 6);
    run("R10", 3000, 1, 2, 25, 0, 0);
    run("R11", 3000, 2, 1, 20, 60, 5);
    // R8 reset in the middle of traffic
    @(negedge clk);
    rst_ni = 1'b0;
    phase_tag = "R8";
    step();
    chk(W'(tx_ser), '0, "R8", "mid reset tx_ser");
    chk(rx_byte, '0, "R8", "mid reset rx_byte");
    rst_ni = 1'b1;
    run("R8", 1000, 2, 2, 40, 0, 0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog (%s) got=hung exp=finished", phase_tag);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule